// File: doc/BRIEF.md
# Operate Group-Two Skip Evaluator

This block evaluates the second group of operate microinstructions for a 12-bit accumulator machine. It takes an instruction word together with the current accumulator, link, switch register and 15-bit program counter. It then decides whether the following instruction is skipped. It also applies the optional accumulator clear and switch-register OR, and raises a halt strobe when the word asks for one. The caller fetches the instruction and stops the machine clock; this block only computes results.

Three condition tests can be selected: negative accumulator, zero accumulator and set link. A sense bit changes how they combine. In normal sense the skip is taken when any selected test holds. In reversed sense the skip is taken only when none of the selected tests holds, so a reversed word with no tests selected always skips. All results are registered and appear one cycle after an accepted input, qualified by a valid output.

Top module: `skip_eval`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it, valid_o, acc_we_o and halt_o are low.
- R2: A word is evaluated as group two only when bits 11:8 are 4'b1111 and bit 0 is 0. Any other word gives no skip, no accumulator write and no halt: next_pc_o is the program counter plus one and acc_o equals acc_i.
- R3: Normal sense (bit 3 = 0). Bit 6 tests acc_i[11] = 1, bit 5 tests acc_i = 0 and bit 4 tests link_i = 1. The skip is taken if any selected test holds.
- R4: Reversed sense (bit 3 = 1). The skip is taken only if none of the tests selected by bits 6, 5 and 4 holds; equivalently, every selected test is seen inverted (accumulator positive or zero, non-zero, link clear).
- R5: With bits 6:4 all zero, reversed sense skips unconditionally and normal sense never skips.
- R6: The condition tests use acc_i as it was before any clear.
- R7: Bit 7 clears the accumulator and raises acc_we_o.
- R8: Bit 2 ORs sr_i into the accumulator and raises acc_we_o. When bits 7 and 2 are both set, the clear comes first, so acc_o equals sr_i.
- R9: When neither bit 7 nor bit 2 is set, acc_we_o is low and acc_o equals acc_i.
- R10: next_pc_o keeps pc_i[14:12]. Its low 12 bits are pc_i[11:0] plus one, plus one more when the skip is taken, wrapping within 12 bits.
- R11: Bit 1 of a group-two word makes halt_o high for exactly the one cycle in which that word's results are valid.
- R12: valid_o is high exactly one cycle after a cycle with valid_i high, and every output belongs to that input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word and operands are valid this cycle |
| instr_i | input | 12 | Instruction word |
| acc_i | input | 12 | Current accumulator |
| link_i | input | 1 | Current link bit |
| sr_i | input | 12 | Switch register value |
| pc_i | input | 15 | Current program counter (field plus 12-bit address) |
| valid_o | output | 1 | Results valid |
| next_pc_o | output | 15 | Program counter of the next instruction |
| acc_o | output | 12 | New accumulator value |
| acc_we_o | output | 1 | Accumulator write enable |
| halt_o | output | 1 | One-cycle halt request |

## Verification
The clear and the zero or sign test can both act on the same word. Because the tests must see the accumulator from before the clear, the bench sends words that combine a clear with a zero or negative test on accumulators that would give the opposite outcome after clearing. It then checks that the skip follows the original value while acc_o reads zero. A halt request and a taken skip can also fall in the same result cycle. The bench sends a halting word with a true test and checks both the doubled program-counter step and the halt pulse. In the next cycle it checks that halt_o has dropped.

// File: rtl/skip_pkg.sv
package skip_pkg;
  localparam int unsigned WORD_W  = 12;
  localparam int unsigned ADDR_W  = 15;
  localparam int unsigned N_COND  = 3;

  // instruction bit positions
  localparam int unsigned B_CLR   = 7;
  localparam int unsigned B_NEG   = 6;
  localparam int unsigned B_ZERO  = 5;
  localparam int unsigned B_LINK  = 4;
  localparam int unsigned B_REV   = 3;
  localparam int unsigned B_ORSW  = 2;
  localparam int unsigned B_HALT  = 1;
  localparam int unsigned B_GRP   = 0;

  localparam int unsigned C_NEG   = 0;
  localparam int unsigned C_ZERO  = 1;
  localparam int unsigned C_LINK  = 2;

  typedef struct packed {
    logic              clr;
    logic [N_COND-1:0] sel;
    logic              rev;
    logic              orsw;
    logic              halt;
  } micro_t;
endpackage

// File: rtl/opr2_decode.sv
module opr2_decode
  import skip_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic [W-1:0] instr_i,
  output logic         is_grp2_o,
  output micro_t       micro_o
);
  localparam int unsigned TOP_W = 4;
  localparam logic [TOP_W-1:0] TOP_CODE = '1;

  assign is_grp2_o = (instr_i[W-1 -: TOP_W] == TOP_CODE) && !instr_i[B_GRP];

  always_comb begin
    micro_o              = '0;
    micro_o.clr          = instr_i[B_CLR];
    micro_o.sel[C_NEG]   = instr_i[B_NEG];
    micro_o.sel[C_ZERO]  = instr_i[B_ZERO];
    micro_o.sel[C_LINK]  = instr_i[B_LINK];
    micro_o.rev          = instr_i[B_REV];
    micro_o.orsw         = instr_i[B_ORSW];
    micro_o.halt         = instr_i[B_HALT];
  end
endmodule

// File: rtl/skip_cond.sv
module skip_cond
  import skip_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic [N_COND-1:0] sel_i,
  input  logic              rev_i,
  input  logic [W-1:0]      acc_i,
  input  logic              link_i,
  output logic              skip_o
);
  logic [N_COND-1:0] cond;
  logic [N_COND-1:0] hit;

  assign cond[C_NEG]  = acc_i[W-1];
  assign cond[C_ZERO] = (acc_i == '0);
  assign cond[C_LINK] = link_i;

  for (genvar g = 0; g < N_COND; g++) begin : g_hit
    assign hit[g] = sel_i[g] & cond[g];
  end

  // reversed sense: no selected test may hold; empty set skips
  assign skip_o = rev_i ? ~|hit : |hit;
endmodule

// File: rtl/acc_update.sv
module acc_update #(
  parameter int unsigned W = skip_pkg::WORD_W
) (
  input  logic         clr_i,
  input  logic         orsw_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] sr_i,
  output logic [W-1:0] acc_o,
  output logic         we_o
);
  logic [W-1:0] cleared;

  assign cleared = clr_i ? '0 : acc_i;
  assign acc_o   = cleared | (orsw_i ? sr_i : '0);
  assign we_o    = clr_i | orsw_i;
endmodule

// File: rtl/pc_advance.sv
module pc_advance #(
  parameter int unsigned AW = skip_pkg::ADDR_W,
  parameter int unsigned LW = skip_pkg::WORD_W
) (
  input  logic [AW-1:0] pc_i,
  input  logic          skip_i,
  output logic [AW-1:0] next_pc_o
);
  localparam int unsigned FW = AW - LW;
  logic [LW-1:0] low;

  assign low       = pc_i[LW-1:0] + LW'(1) + LW'(skip_i);
  assign next_pc_o = {pc_i[AW-1 -: FW], low};
endmodule

// File: rtl/skip_eval.sv
module skip_eval
  import skip_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [W-1:0]  instr_i,
  input  logic [W-1:0]  acc_i,
  input  logic          link_i,
  input  logic [W-1:0]  sr_i,
  input  logic [AW-1:0] pc_i,
  output logic          valid_o,
  output logic [AW-1:0] next_pc_o,
  output logic [W-1:0]  acc_o,
  output logic          acc_we_o,
  output logic          halt_o
);
  logic          is_grp2;
  micro_t        micro;
  logic          skip_raw, skip;
  logic [W-1:0]  acc_new;
  logic          we_raw;
  logic [AW-1:0] pc_new;

  opr2_decode #(.W(W)) u_dec (
    .instr_i  (instr_i),
    .is_grp2_o(is_grp2),
    .micro_o  (micro)
  );

  skip_cond #(.W(W)) u_cond (
    .sel_i (micro.sel),
    .rev_i (micro.rev),
    .acc_i (acc_i),
    .link_i(link_i),
    .skip_o(skip_raw)
  );

  acc_update #(.W(W)) u_acc (
    .clr_i (micro.clr & is_grp2),
    .orsw_i(micro.orsw & is_grp2),
    .acc_i (acc_i),
    .sr_i  (sr_i),
    .acc_o (acc_new),
    .we_o  (we_raw)
  );

  assign skip = skip_raw & is_grp2;

  pc_advance #(.AW(AW), .LW(W)) u_pc (
    .pc_i     (pc_i),
    .skip_i   (skip),
    .next_pc_o(pc_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      acc_we_o  <= 1'b0;
      halt_o    <= 1'b0;
      next_pc_o <= '0;
      acc_o     <= '0;
    end else begin
      valid_o  <= valid_i;
      acc_we_o <= valid_i & we_raw;
      halt_o   <= valid_i & is_grp2 & micro.halt;
      if (valid_i) begin
        next_pc_o <= pc_new;
        acc_o     <= acc_new;
      end
    end
  end
endmodule

// File: rtl/skip_eval_chk.sv
module skip_eval_chk #(
  parameter int unsigned W  = 12,
  parameter int unsigned AW = 15
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [W-1:0]  instr_i,
  input logic [W-1:0]  acc_i,
  input logic [AW-1:0] pc_i,
  input logic          valid_o,
  input logic [AW-1:0] next_pc_o,
  input logic [W-1:0]  acc_o,
  input logic          acc_we_o,
  input logic          halt_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  logic grp2_in;
  assign grp2_in = (instr_i[W-1:W-4] == 4'hF) && !instr_i[0];

  assert_valid_follow_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (valid_o == $past(valid_i)));

  assert_halt_qual_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> valid_o);

  assert_halt_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && halt_o) |-> !$past(halt_o) || $past(valid_i));

  assert_we_qual_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_we_o |-> valid_o);

  assert_field_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && valid_o) |-> (next_pc_o[AW-1:W] == $past(pc_i[AW-1:W])));

  assert_step_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && valid_o) |->
      ((W'(next_pc_o[W-1:0] - $past(pc_i[W-1:0])) == W'(1)) ||
       (W'(next_pc_o[W-1:0] - $past(pc_i[W-1:0])) == W'(2))));

  assert_nongrp_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && valid_o && !$past(grp2_in)) |->
      (!acc_we_o && !halt_o && (acc_o == $past(acc_i))));

  assert_uncond_skip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && valid_o && $past(grp2_in) && $past(instr_i[6:3]) == 4'b0001) |->
      (W'(next_pc_o[W-1:0] - $past(pc_i[W-1:0])) == W'(2)));

  assert_clear_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && valid_o && $past(grp2_in) && $past(instr_i[7]) && !$past(instr_i[2])) |->
      (acc_we_o && acc_o == '0));
endmodule

bind skip_eval skip_eval_chk #(.W(W), .AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .instr_i  (instr_i),
  .acc_i    (acc_i),
  .pc_i     (pc_i),
  .valid_o  (valid_o),
  .next_pc_o(next_pc_o),
  .acc_o    (acc_o),
  .acc_we_o (acc_we_o),
  .halt_o   (halt_o)
);

// File: tb/sim_skip_eval.sv
module sim_skip_eval;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [11:0] instr_i = '0;
  logic [11:0] acc_i = '0;
  logic        link_i = 1'b0;
  logic [11:0] sr_i = '0;
  logic [14:0] pc_i = '0;
  logic        valid_o;
  logic [14:0] next_pc_o;
  logic [11:0] acc_o;
  logic        acc_we_o;
  logic        halt_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  skip_eval u0 (
    .clk_i, .rst_ni, .valid_i, .instr_i, .acc_i, .link_i, .sr_i, .pc_i,
    .valid_o, .next_pc_o, .acc_o, .acc_we_o, .halt_o
  );

  typedef struct {
    logic [14:0] pc;
    logic [11:0] acc;
    logic        we;
    logic        halt;
    string       tag;
  } exp_t;

  exp_t sb[$];

  function automatic exp_t model(logic [11:0] ins, logic [11:0] a, logic l,
                                 logic [11:0] s, logic [14:0] p, string tag);
    exp_t e;
    logic grp, hit_any, skp;
    grp = (ins[11:8] == 4'hF) && !ins[0];
    hit_any = (ins[6] && a[11]) || (ins[5] && a == 0) || (ins[4] && l);
    skp = grp && (ins[3] ? !hit_any : hit_any);
    e.pc   = {p[14:12], 12'(p[11:0] + 12'd1 + (skp ? 12'd1 : 12'd0))};
    e.acc  = a;
    e.we   = 1'b0;
    if (grp) begin
      if (ins[7]) e.acc = '0;
      if (ins[2]) e.acc = e.acc | s;
      e.we = ins[7] | ins[2];
    end
    e.halt = grp & ins[1];
    e.tag  = tag;
    return e;
  endfunction

  task automatic send(logic [11:0] ins, logic [11:0] a, logic l,
                      logic [11:0] s, logic [14:0] p, string tag);
    instr_i = ins; acc_i = a; link_i = l; sr_i = s; pc_i = p; valid_i = 1'b1;
    sb.push_back(model(ins, a, l, s, p, tag));
    @(negedge clk_i);
  endtask

  task automatic idle(int n);
    valid_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(bit ok, string tag, string what, int act, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0o expected %0o", tag, what, act, exp_v);
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (valid_o) begin
        if (sb.size() == 0) begin
          chk(0, "R12", "unexpected valid_o", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(next_pc_o == e.pc, e.tag, "next_pc (R10)", int'(next_pc_o), int'(e.pc));
          chk(acc_o == e.acc, e.tag, "acc", int'(acc_o), int'(e.acc));
          chk(acc_we_o == e.we, e.tag, "acc_we", int'(acc_we_o), int'(e.we));
          chk(halt_o == e.halt, e.tag, "halt (R11)", int'(halt_o), int'(e.halt));
        end
      end else begin
        chk(!halt_o && !acc_we_o, "R11", "strobe without valid", int'({halt_o, acc_we_o}), 0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!valid_o && !acc_we_o && !halt_o, "R1", "reset outputs",
        int'({valid_o, acc_we_o, halt_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!valid_o && !acc_we_o && !halt_o, "R1", "first cycle after reset",
        int'({valid_o, acc_we_o, halt_o}), 0);

    // R3 normal sense, each test true and false
    send(12'o7500, 12'o4000, 0, 0, 15'o10100, "R3_neg_true");
    send(12'o7500, 12'o3777, 0, 0, 15'o10100, "R3_neg_false");
    send(12'o7440, 12'o0000, 0, 0, 15'o00200, "R3_zero_true");
    send(12'o7440, 12'o0001, 0, 0, 15'o00200, "R3_zero_false");
    send(12'o7420, 12'o0005, 1, 0, 15'o00300, "R3_link_true");
    send(12'o7420, 12'o0005, 0, 0, 15'o00300, "R3_link_false");
    send(12'o7560, 12'o0005, 1, 0, 15'o00400, "R3_or_one_holds");
    send(12'o7560, 12'o0005, 0, 0, 15'o00400, "R3_or_none_holds");
    // R4 reversed sense
    send(12'o7510, 12'o0001, 0, 0, 15'o20000, "R4_pos_skip");
    send(12'o7510, 12'o4001, 0, 0, 15'o20000, "R4_neg_noskip");
    send(12'o7450, 12'o0007, 0, 0, 15'o20000, "R4_nonzero_skip");
    send(12'o7450, 12'o0000, 0, 0, 15'o20000, "R4_zero_noskip");
    send(12'o7430, 12'o0000, 0, 0, 15'o20000, "R4_linkclr_skip");
    send(12'o7570, 12'o0003, 0, 0, 15'o20000, "R4_all_inverted_skip");
    send(12'o7570, 12'o0003, 1, 0, 15'o20000, "R4_link_blocks");
    // R5 empty condition sets
    send(12'o7410, 12'o4000, 1, 0, 15'o30010, "R5_reversed_empty");
    send(12'o7400, 12'o4000, 1, 0, 15'o30010, "R5_normal_empty");
    // R6 + R7 clear with tests on old value
    send(12'o7640, 12'o0012, 0, 0, 15'o01000, "R6_clear_zero_noskip");
    send(12'o7700, 12'o4321, 0, 0, 15'o01000, "R6_clear_neg_skip");
    send(12'o7600, 12'o1234, 0, 12'o7777, 15'o01000, "R7_clear");
    // R8 OR switch, clear then OR
    send(12'o7404, 12'o1200, 0, 12'o0034, 15'o01000, "R8_or");
    send(12'o7604, 12'o7777, 0, 12'o0505, 15'o01000, "R8_clear_then_or");
    // R9 no accumulator change
    send(12'o7440, 12'o0555, 0, 12'o7777, 15'o01000, "R9_passthrough");
    // R10 wrap in low 12 bits, field kept
    send(12'o7410, 12'o0000, 0, 0, 15'o57776, "R10_wrap_skip");
    send(12'o7400, 12'o0000, 0, 0, 15'o57777, "R10_wrap_noskip");
    // R11 halt with taken skip, then gap
    send(12'o7442, 12'o0000, 0, 0, 15'o00100, "R11_halt_skip");
    idle(2);
    send(12'o7402, 12'o0001, 0, 0, 15'o00100, "R11_halt_alone");
    send(12'o7400, 12'o0001, 0, 0, 15'o00100, "R11_no_halt_after");
    // R2 words outside group two
    send(12'o7401, 12'o0000, 1, 12'o7777, 15'o00500, "R2_bit0_set");
    send(12'o7240, 12'o0000, 1, 12'o7777, 15'o00500, "R2_group_one");
    send(12'o5606, 12'o0000, 1, 12'o7777, 15'o00500, "R2_other_op");
    send(12'o6402, 12'o4000, 0, 12'o7777, 15'o00500, "R2_io_word");
    idle(3);
    chk(sb.size() == 0, "R12", "results outstanding", sb.size(), 0);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule